// File: doc/BRIEF.md
# Defect-Skipping Readout Address Sequencer

This block produces the row and column addresses that scan a sensor array in row-major order. A small table of defect entries tells it which lines to leave out. Each entry names either a row or a column. A row entry removes the whole row from the scan, so one bad pixel needs only its row number stored. A column entry removes that column from every row. Rows with defects are stepped over one per enabled cycle. Defective columns are stepped over inside the same cycle, through a short lookahead past the current column.

The array size is given as last-row and last-column indices. The scan is started with a pulse. Each enabled cycle then either emits one valid pixel address or drops one line. A one-cycle completion pulse follows the last line. The table and the array size are copied into working registers when a frame starts. Writes made during a frame therefore only affect later frames.

Top module: `defect_scan_seq`

## Requirements
- R1: After reset, `pix_valid` and `frame_done` are low, `row_addr` and `col_addr` are zero, and every table entry is disabled, so the first frame is a full raster.
- R2: Within a frame, good pixels come out in row-major order, ascending in both row and column, each exactly once, with rows 0..`lim_row` and columns 0..`lim_col`.
- R3: A row named by an enabled row entry never appears, and each such row takes exactly one enabled cycle with `pix_valid` low.
- R4: A column named by an enabled column entry never appears in any row, and it costs no cycle.
- R5: When the scan moves to a new row, the column restarts at the lowest column that is not defective.
- R6: While `ce` is low, the scan does not advance, and `pix_valid` is low in the following cycle.
- R7: `frame_done` is high for exactly one cycle, one cycle after the final scan step, and never together with `pix_valid`. If every row is defective, the frame emits no pixel and ends after `lim_row`+1 enabled cycles.
- R8: Table writes made while a frame is active take effect only from the next frame. A `start` pulse during a frame is ignored.
- R9: There are four entries, each with a 10-bit address. A write with `wr_en` high stores `wr_on` (1 = entry enabled), `wr_col` (1 = column entry, 0 = row entry) and `wr_addr` into entry `wr_sel`. A disabled entry has no effect.
- R10: With `ce` held high, the first scan step's outputs appear two clock edges after the edge that samples `start`. `frame_done` is visible at edge `start`+2+S, where S is the number of emitted pixels plus the number of dropped rows.
- R11: Entries that address a line outside the programmed size have no effect. A row whose columns are all defective is dropped like a defective row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame when the sequencer is idle |
| ce | input | 1 | Clock enable for scan steps |
| lim_row | input | 10 | Index of the last row, latched at start |
| lim_col | input | 10 | Index of the last column, latched at start |
| wr_en | input | 1 | Defect table write strobe |
| wr_sel | input | 2 | Entry index to write |
| wr_on | input | 1 | Entry enable |
| wr_col | input | 1 | 1 = column entry, 0 = row entry |
| wr_addr | input | 10 | Line address of the entry |
| row_addr | output | 10 | Row address of the current pixel |
| col_addr | output | 10 | Column address of the current pixel |
| pix_valid | output | 1 | Address pair is a good pixel |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
A wrong row cursor or a wrong row-match shows up in the very next enabled cycle as an address out of order or a defective row on the outputs. A wrong column lookahead emits a listed column, or leaves out a good one, in the same row. Mistakes in the end-of-frame or skip-cycle logic move `frame_done` away from the cycle predicted from the count of pixels plus dropped rows, so a single frame shows them. Faults in the working copy of the table show up only in the frame after a mid-frame write, and the bench checks that frame.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int DSQ_AW_DEF = 10;
  localparam int DSQ_N_DEF  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_SCAN = 2'd2,
    ST_FIN  = 2'd3
  } dsq_state_e;
endpackage

// File: rtl/dsq_defect_table.sv
module dsq_defect_table #(
  parameter int AW = 10,
  parameter int N  = 4,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_sel,
  input  logic                 wr_on,
  input  logic                 wr_col,
  input  logic [AW-1:0]        wr_addr,
  input  logic                 load,
  input  logic                 busy,
  output logic [N-1:0]         act_vld,
  output logic [N-1:0]         act_col,
  output logic [N-1:0][AW-1:0] act_addr
);
  // programmed copy, written by the register port at any time
  logic [N-1:0]         sh_vld;
  logic [N-1:0]         sh_col;
  logic [N-1:0][AW-1:0] sh_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_vld  <= '0;
      sh_col  <= '0;
      sh_addr <= '0;
    end else if (wr_en && (int'(wr_sel) < N)) begin
      sh_vld[wr_sel]  <= wr_on;
      sh_col[wr_sel]  <= wr_col;
      sh_addr[wr_sel] <= wr_addr;
    end
  end

  // working copy, frozen for the duration of a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      act_vld  <= '0;
      act_col  <= '0;
      act_addr <= '0;
    end else if (load) begin
      act_vld  <= sh_vld;
      act_col  <= sh_col;
      act_addr <= sh_addr;
    end
  end

  // R8
  tbl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(act_vld) && $stable(act_col) && $stable(act_addr)));
endmodule

// File: rtl/dsq_col_lookahead.sv
module dsq_col_lookahead #(
  parameter int AW = 10,
  parameter int N  = 4
) (
  input  logic [AW:0]          base,
  input  logic [N-1:0]         act_vld,
  input  logic [N-1:0]         act_col,
  input  logic [N-1:0][AW-1:0] act_addr,
  output logic [AW:0]          nxt
);
  localparam int CW = AW + 1;
  localparam int NC = N + 1;  // N entries can block at most N candidates

  logic [NC-1:0]         hit;
  logic [NC-1:0][CW-1:0] cand;

  for (genvar k = 0; k < NC; k++) begin : g_cand
    assign cand[k] = base + CW'(k);
    always_comb begin
      hit[k] = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (act_vld[i] && act_col[i] && ({1'b0, act_addr[i]} == cand[k]))
          hit[k] = 1'b1;
      end
    end
  end

  always_comb begin
    nxt = cand[NC-1];
    for (int k = NC - 1; k >= 0; k--) begin
      if (!hit[k]) nxt = cand[k];
    end
  end
endmodule

// File: rtl/dsq_scan_ctrl.sv
module dsq_scan_ctrl
  import dsq_pkg::*;
#(
  parameter int AW = 10,
  parameter int N  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 ce,
  input  logic [AW-1:0]        lim_row,
  input  logic [AW-1:0]        lim_col,
  input  logic [N-1:0]         act_vld,
  input  logic [N-1:0]         act_col,
  input  logic [N-1:0][AW-1:0] act_addr,
  input  logic [AW:0]          first_col,
  input  logic [AW:0]          next_col,
  output logic [AW-1:0]        cur_col,
  output logic                 load,
  output logic                 busy,
  output logic [AW-1:0]        row_addr,
  output logic [AW-1:0]        col_addr,
  output logic                 pix_valid,
  output logic                 frame_done
);
  dsq_state_e    st;
  logic [AW-1:0] r, c, lr, lc;
  logic [AW-1:0] row_q, col_q;
  logic          pv_q, done_q;
  logic          row_hit, out_row_hit;
  logic          first_ok, next_ok, row_skip, stay_row;

  always_comb begin
    row_hit     = 1'b0;
    out_row_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (act_vld[i] && !act_col[i] && (act_addr[i] == r))     row_hit     = 1'b1;
      if (act_vld[i] && !act_col[i] && (act_addr[i] == row_q)) out_row_hit = 1'b1;
    end
  end

  assign first_ok = (first_col <= {1'b0, lc});
  assign next_ok  = (next_col  <= {1'b0, lc});
  assign row_skip = row_hit || !first_ok;
  assign stay_row = !row_skip && next_ok;
  assign load     = (st == ST_IDLE) && start;
  assign busy     = (st != ST_IDLE);
  assign cur_col  = c;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      r      <= '0;
      c      <= '0;
      lr     <= '0;
      lc     <= '0;
      row_q  <= '0;
      col_q  <= '0;
      pv_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pv_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            lr <= lim_row;
            lc <= lim_col;
            st <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          r  <= '0;
          c  <= first_col[AW-1:0];
          st <= ST_SCAN;
        end
        ST_SCAN: begin
          if (ce) begin
            if (!row_skip) begin
              pv_q  <= 1'b1;
              row_q <= r;
              col_q <= c;
            end
            if (stay_row) begin
              c <= next_col[AW-1:0];
            end else if (r == lr) begin
              st <= ST_FIN;
            end else begin
              r <= r + AW'(1);
              c <= first_col[AW-1:0];
            end
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign row_addr   = row_q;
  assign col_addr   = col_q;
  assign pix_valid  = pv_q;
  assign frame_done = done_q;

  // R6
  hold_on_ce_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !pix_valid);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R7
  done_no_pix_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !pix_valid);
  // R2
  col_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_valid) && (row_addr == $past(row_addr)))
      |-> (col_addr > $past(col_addr)));
  // R2
  in_range_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ((row_addr <= lr) && (col_addr <= lc)));
  // R3
  bad_row_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> !out_row_hit);
endmodule

// File: rtl/defect_scan_seq.sv
module defect_scan_seq #(
  parameter int AW = dsq_pkg::DSQ_AW_DEF,
  parameter int N  = dsq_pkg::DSQ_N_DEF,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ce,
  input  logic [AW-1:0] lim_row,
  input  logic [AW-1:0] lim_col,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic          wr_on,
  input  logic          wr_col,
  input  logic [AW-1:0] wr_addr,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr,
  output logic          pix_valid,
  output logic          frame_done
);
  logic [N-1:0]         act_vld, act_col;
  logic [N-1:0][AW-1:0] act_addr;
  logic [AW:0]          first_col, next_col, next_base;
  logic [AW-1:0]        cur_col;
  logic                 load, busy;

  dsq_defect_table #(.AW(AW), .N(N), .SW(SW)) tbl_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_on(wr_on), .wr_col(wr_col), .wr_addr(wr_addr),
    .load(load), .busy(busy),
    .act_vld(act_vld), .act_col(act_col), .act_addr(act_addr)
  );

  dsq_col_lookahead #(.AW(AW), .N(N)) first_i (
    .base('0), .act_vld(act_vld), .act_col(act_col), .act_addr(act_addr), .nxt(first_col)
  );

  assign next_base = {1'b0, cur_col} + (AW+1)'(1);

  dsq_col_lookahead #(.AW(AW), .N(N)) next_i (
    .base(next_base), .act_vld(act_vld), .act_col(act_col), .act_addr(act_addr), .nxt(next_col)
  );

  dsq_scan_ctrl #(.AW(AW), .N(N)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .ce(ce),
    .lim_row(lim_row), .lim_col(lim_col),
    .act_vld(act_vld), .act_col(act_col), .act_addr(act_addr),
    .first_col(first_col), .next_col(next_col), .cur_col(cur_col),
    .load(load), .busy(busy),
    .row_addr(row_addr), .col_addr(col_addr), .pix_valid(pix_valid), .frame_done(frame_done)
  );

  for (genvar i = 0; i < N; i++) begin : g_colchk
    // R4
    bad_col_hidden_chk: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> !(act_vld[i] && act_col[i] && (act_addr[i] == col_addr)));
  end
endmodule

// File: tb/defect_scan_seq_tb_top.sv
module defect_scan_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam int N  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, ce = 1'b1;
  logic [AW-1:0] lim_row = '0, lim_col = '0;
  logic          wr_en = 1'b0, wr_on = 1'b0, wr_col = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [AW-1:0] row_addr, col_addr;
  logic          pix_valid, frame_done;

  int checks = 0;
  int fails  = 0;
  int m_on [N];
  int m_col[N];
  int m_adr[N];

  always #(CLK_P/2) clk = ~clk;

  defect_scan_seq #(.AW(AW), .N(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .ce(ce), .lim_row(lim_row), .lim_col(lim_col),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_on(wr_on), .wr_col(wr_col), .wr_addr(wr_addr),
    .row_addr(row_addr), .col_addr(col_addr), .pix_valid(pix_valid), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ent(input int sel, input int on, input int col, input int adr);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_on = on[0]; wr_col = col[0]; wr_addr = AW'(adr);
    @(negedge clk);
    wr_en = 1'b0;
    m_on[sel] = on; m_col[sel] = col; m_adr[sel] = adr;
  endtask

  // mid: 1 = write row entry 1 into slot 3 and pulse start during the frame
  task automatic run_frame(input int nr, input int nc, input int ce_mode, input int mid);
    int q_r[$];
    int q_c[$];
    int steps = 0;
    int n = 0;
    int ndone = 0;
    bit pce;
    for (int r = 0; r < nr; r++) begin
      bit rb = 0;
      int cnt = 0;
      for (int i = 0; i < N; i++) if (m_on[i] != 0 && m_col[i] == 0 && m_adr[i] == r) rb = 1;
      for (int c = 0; c < nc; c++) begin
        bit cb = 0;
        for (int i = 0; i < N; i++) if (m_on[i] != 0 && m_col[i] != 0 && m_adr[i] == c) cb = 1;
        if (!cb) cnt++;
      end
      if (rb || cnt == 0) steps++;
      else begin
        steps += cnt;
        for (int c = 0; c < nc; c++) begin
          bit cb = 0;
          for (int i = 0; i < N; i++) if (m_on[i] != 0 && m_col[i] != 0 && m_adr[i] == c) cb = 1;
          if (!cb) begin q_r.push_back(r); q_c.push_back(c); end
        end
      end
    end
    @(negedge clk);
    lim_row = AW'(nr - 1); lim_col = AW'(nc - 1); ce = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (ndone == 0 && n < 2000) begin
      if (ce_mode != 0) ce = ((n % 3) != 1);
      pce = ce;
      @(negedge clk);
      n++;
      wr_en = 1'b0; start = 1'b0;
      if (pix_valid) begin
        chk(pce, "R6 valid after ce low", 1, 0);
        if (q_r.size() == 0) chk(0, "R2 extra pixel", int'(row_addr), -1);
        else begin
          chk(int'(row_addr) == q_r[0] && int'(col_addr) == q_c[0], "R2/R3/R4/R5 pixel address",
              int'(row_addr) * 1024 + int'(col_addr), q_r[0] * 1024 + q_c[0]);
          void'(q_r.pop_front()); void'(q_c.pop_front());
        end
      end
      if (frame_done) begin
        ndone = 1;
        chk(!pix_valid, "R7 done with valid", 1, 0);
      end
      if (mid != 0 && n == 3) begin
        wr_en = 1'b1; wr_sel = 2'd3; wr_on = 1'b1; wr_col = 1'b0; wr_addr = AW'(1);
        m_on[3] = 1; m_col[3] = 0; m_adr[3] = 1;
        start = 1'b1;
      end
    end
    chk(ndone == 1, "R7 frame_done seen", ndone, 1);
    chk(q_r.size() == 0, "R2 missing pixels", q_r.size(), 0);
    if (ce_mode == 0 && mid == 0) chk(n == steps + 2, "R10/R3 frame length", n, steps + 2);
    ce = 1'b1;
    @(negedge clk);
    chk(!frame_done, "R7 done single cycle", int'(frame_done), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_on[i] = 0; m_col[i] = 0; m_adr[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!pix_valid && !frame_done, "R1 flags after reset", int'(pix_valid) + int'(frame_done), 0);
    chk(row_addr == '0 && col_addr == '0, "R1 addresses after reset", int'(row_addr) + int'(col_addr), 0);
    rst = 1'b0;
    // R1 empty table gives a full raster
    run_frame(3, 4, 0, 0);
    // R9 sweep over entry patterns (enabled and disabled, row and column, in and out of range: R11)
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < N; i++)
        write_ent(i, ((p + i) % 3 != 0) ? 1 : 0, (i + p) % 2, (p * 2 + i * 3) % 7);
      for (int nr = 1; nr <= 5; nr++)
        for (int nc = 1; nc <= 5; nc++)
          run_frame(nr, nc, 0, 0);
    end
    // R7 all rows defective
    write_ent(0, 1, 0, 0); write_ent(1, 1, 0, 1); write_ent(2, 1, 0, 2); write_ent(3, 0, 0, 0);
    run_frame(3, 4, 0, 0);
    // R11 all columns defective, and entry at the top address out of range
    write_ent(0, 1, 1, 0); write_ent(1, 1, 1, 1); write_ent(2, 1, 0, 1023); write_ent(3, 1, 1, 1023);
    run_frame(4, 2, 0, 0);
    run_frame(3, 4, 0, 0);
    // R6 gated clock enable with a column defect
    write_ent(0, 1, 1, 2); write_ent(1, 1, 0, 1); write_ent(2, 0, 0, 0); write_ent(3, 0, 0, 0);
    run_frame(4, 5, 1, 0);
    // R8 mid-frame write and start pulse; next frame sees the new entry
    write_ent(0, 0, 0, 0); write_ent(1, 0, 0, 0);
    run_frame(4, 3, 0, 1);
    run_frame(4, 3, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule